// File: doc/BRIEF.md
# Network Controller Command and Interrupt Status Registers

This block is the host-facing command and interrupt window of a network controller. The host sees three registers behind a small register bus: an event/state word, a command word and a 32-bit operand pointer. Internal units raise single-cycle event pulses and report their state. The host reads these through the event/state word. It clears events by writing ones to the upper byte of that word. A single interrupt output is high whenever an unmasked event is pending.

To issue work, the host loads the pointer and then writes the command word. The command word carries an opcode for the transmit/command unit, an opcode for the receive unit, an interrupt mask bit and a software-interrupt trigger. Each opcode is offered to its unit over a valid/ready pair, together with a copy of the pointer taken when the command was written. The offer is held until that unit's ready is sampled high. Until then the opcode field reads back nonzero. When both fields read zero, the host may issue the next command.

Back-pressure rules: a unit may hold its ready low for any number of cycles. While it does, the opcode and the operand on its side stay stable. A transfer happens on a rising edge where valid and ready are both high. The field clears at that edge unless a new legal command write for the same field lands on the same edge, in which case the new command replaces it. Ready asserted with nothing pending has no effect.

Top module: `nic_ctl_regs`

## Requirements
- R1: After reset all event flags, both opcode fields, the mask bit, the pointer register and `irq` are zero.
- R2: A pulse on `unit_events[i]` sets event flag i, read at status bit 8+i, for i in {7,6,5,4,3,0}. These are status bits 15 finished command, 14 frame received, 13 command unit left active, 12 receiver left ready, 11 management cycle done and 8 flow-control pause. Input bits 2 and 1 are ignored. A set flag stays set until it is acknowledged.
- R3: A write to address 0 clears every flag whose position is a 1 in `host_wdata[15:8] & 8'hFD`, which is the status mask 0xFD00. Flags at positions written with 0, and all other written bits, are unchanged.
- R4: If an event pulse and an acknowledge of the same flag fall on the same edge, the flag stays set.
- R5: A write to address 1 with bit 9 = 1 sets the software-interrupt flag at status bit 10. Command bit 9 always reads back 0.
- R6: A command write loads the command-unit opcode from bits 7:4 only if it is one of 1,2,4,5,6,7. Codes 0, 3 and 8 to 15 leave the field unchanged. While the field is nonzero, `cu_cmd_valid` is 1 and `cu_cmd_op` carries the field.
- R7: A command write loads the receive-unit opcode from bits 2:0 only if it is one of 1,2,4,6,7. Codes 0, 3 and 5 leave the field unchanged. While the field is nonzero, `ru_cmd_valid` is 1 and `ru_cmd_op` carries the field.
- R8: An opcode field clears only at an edge where its own unit's valid and ready are both high. The other unit's field is untouched. The field reads back at command bits 7:4 and 2:0 until it clears.
- R9: Command bit 8 is the interrupt mask and reads back as written. `irq` is registered: it equals (any flag set AND mask = 0) as of the previous edge. It therefore rises one cycle after a flag sets and falls one cycle after the last flag clears or the mask is set.
- R10: Status bits 7:6 show `cu_state` and bits 5:2 show `ru_state` combinationally. In the receive state, 0 means idle, 1 suspended, 2 no resources and 4 ready, with 8 added when buffer descriptors are exhausted. Status bits 1:0 read 0.
- R11: Address 2 reads back the last pointer written. Each loaded opcode carries the pointer value held at the time of its command write, and later pointer writes do not change a pending operand.
- R12: A legal command write to a field that is still pending replaces the opcode and operand. This holds even on the edge where the old command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select: 0 status/ack, 1 command, 2 pointer |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Combinational read data for `host_addr` |
| unit_events | input | 8 | Event pulses aligned to status bits 15:8 |
| cu_state | input | 2 | Command-unit state |
| ru_state | input | 4 | Receive-unit state |
| cu_cmd_valid | output | 1 | Command-unit opcode pending |
| cu_cmd_ready | input | 1 | Command unit takes the opcode |
| cu_cmd_op | output | 4 | Command-unit opcode |
| cu_cmd_ptr | output | 32 | Command-unit operand |
| ru_cmd_valid | output | 1 | Receive-unit opcode pending |
| ru_cmd_ready | input | 1 | Receive unit takes the opcode |
| ru_cmd_op | output | 3 | Receive-unit opcode |
| ru_cmd_ptr | output | 32 | Receive-unit operand |
| irq | output | 1 | Interrupt request |

## Verification
Every one of the 16 command-unit codes and 8 receive-unit codes is written into an empty field. This separates the legal codes that must load and carry their operand from the illegal ones that must leave the field alone. All 256 acknowledge bytes are written against a full set of flags, which shows whether each bit position is cleared or kept and that bit 9 has no effect. All 64 combinations of unit state are read back to check field placement. Directed sequences cover the edge cases. An event and an acknowledge on the same edge must leave the flag set. An accept and a new write on the same edge must keep the new command. Readiness on one unit must not clear the other. The interrupt edges are checked one cycle after flag and mask changes.

// File: rtl/nic_ctl_pkg.sv
package nic_ctl_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CMD    = 2'd1,
    SEL_PTR    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int EV_W = 8;
  localparam logic [EV_W-1:0] HW_EVENT_MASK = 8'hF9;
  localparam logic [EV_W-1:0] ACK_MASK      = 8'hFD;
  localparam int SWI_FLAG_IDX = 2;

  localparam int CMD_RU_LSB  = 0;
  localparam int CMD_CU_LSB  = 4;
  localparam int CMD_MASK_BIT = 8;
  localparam int CMD_SWI_BIT  = 9;

  localparam logic [15:0] CU_LEGAL = 16'h00F6;
  localparam logic [7:0]  RU_LEGAL = 8'hD6;

endpackage

// File: rtl/nic_evt_flags.sv
module nic_evt_flags #(
  parameter int N = 8,
  parameter logic [N-1:0] HW_MASK = '1,
  parameter logic [N-1:0] CLR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_ev,
  input  logic [N-1:0] sw_set,
  input  logic         ack_wr,
  input  logic [N-1:0] ack_bits,
  input  logic         irq_mask,
  output logic [N-1:0] flags,
  output logic         irq
);

  logic [N-1:0] clr_v;
  logic [N-1:0] set_v;

  always_comb begin
    clr_v = ack_wr ? (ack_bits & CLR_MASK) : '0;
    set_v = (hw_ev & HW_MASK) | sw_set;
  end

  // One flop per flag; a set on the same edge beats a clear.
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else if (set_v[i])
        flags[i] <= 1'b1;
      else if (clr_v[i])
        flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq <= 1'b0;
    else
      irq <= (|flags) && !irq_mask;
  end

endmodule

// File: rtl/nic_cmd_slot.sv
module nic_cmd_slot #(
  parameter int OP_W = 4,
  parameter int PTR_W = 32,
  parameter logic [(1<<OP_W)-1:0] LEGAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OP_W-1:0]  wr_op,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [OP_W-1:0]  cmd_op,
  output logic [PTR_W-1:0] cmd_ptr
);

  logic load;
  logic take;

  always_comb begin
    load = wr_en && LEGAL[wr_op];
    take = cmd_valid && cmd_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_op  <= '0;
      cmd_ptr <= '0;
    end else if (load) begin
      cmd_op  <= wr_op;
      cmd_ptr <= wr_ptr;
    end else if (take) begin
      cmd_op  <= '0;
    end
  end

  assign cmd_valid = (cmd_op != '0);

endmodule

// File: rtl/nic_ctl_regs.sv
module nic_ctl_regs
  import nic_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W = 32,
  parameter int CU_OP_W = 4,
  parameter int RU_OP_W = 3,
  parameter int CU_ST_W = 2,
  parameter int RU_ST_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic [1:0]         host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  input  logic [EV_W-1:0]    unit_events,
  input  logic [CU_ST_W-1:0] cu_state,
  input  logic [RU_ST_W-1:0] ru_state,
  output logic               cu_cmd_valid,
  input  logic               cu_cmd_ready,
  output logic [CU_OP_W-1:0] cu_cmd_op,
  output logic [PTR_W-1:0]   cu_cmd_ptr,
  output logic               ru_cmd_valid,
  input  logic               ru_cmd_ready,
  output logic [RU_OP_W-1:0] ru_cmd_op,
  output logic [PTR_W-1:0]   ru_cmd_ptr,
  output logic               irq
);

  localparam int STATE_LSB = 2;
  localparam int STAT_W = 16;

  logic            wr_status;
  logic            wr_cmd;
  logic            wr_ptr;
  logic [EV_W-1:0] flags_q;
  logic [EV_W-1:0] swi_set;
  logic            mask_q;
  logic [PTR_W-1:0] ptr_q;
  logic [STAT_W-1:0] status_word;
  logic [STAT_W-1:0] cmd_word;

  always_comb begin
    wr_status = host_wr_en && (reg_sel_e'(host_addr) == SEL_STATUS);
    wr_cmd    = host_wr_en && (reg_sel_e'(host_addr) == SEL_CMD);
    wr_ptr    = host_wr_en && (reg_sel_e'(host_addr) == SEL_PTR);
    swi_set   = '0;
    swi_set[SWI_FLAG_IDX] = wr_cmd && host_wdata[CMD_SWI_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (wr_cmd) mask_q <= host_wdata[CMD_MASK_BIT];
      if (wr_ptr) ptr_q  <= host_wdata[PTR_W-1:0];
    end
  end

  nic_evt_flags #(
    .N(EV_W), .HW_MASK(HW_EVENT_MASK), .CLR_MASK(ACK_MASK)
  ) u_flags (
    .clk(clk), .rst_n(rst_n),
    .hw_ev(unit_events), .sw_set(swi_set),
    .ack_wr(wr_status), .ack_bits(host_wdata[STAT_W-1:STAT_W-EV_W]),
    .irq_mask(mask_q), .flags(flags_q), .irq(irq)
  );

  nic_cmd_slot #(
    .OP_W(CU_OP_W), .PTR_W(PTR_W), .LEGAL(CU_LEGAL[(1<<CU_OP_W)-1:0])
  ) u_cu_slot (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_cmd), .wr_op(host_wdata[CMD_CU_LSB +: CU_OP_W]), .wr_ptr(ptr_q),
    .cmd_valid(cu_cmd_valid), .cmd_ready(cu_cmd_ready),
    .cmd_op(cu_cmd_op), .cmd_ptr(cu_cmd_ptr)
  );

  nic_cmd_slot #(
    .OP_W(RU_OP_W), .PTR_W(PTR_W), .LEGAL(RU_LEGAL[(1<<RU_OP_W)-1:0])
  ) u_ru_slot (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_cmd), .wr_op(host_wdata[CMD_RU_LSB +: RU_OP_W]), .wr_ptr(ptr_q),
    .cmd_valid(ru_cmd_valid), .cmd_ready(ru_cmd_ready),
    .cmd_op(ru_cmd_op), .cmd_ptr(ru_cmd_ptr)
  );

  always_comb begin
    status_word = '0;
    status_word[STAT_W-1 -: EV_W] = flags_q;
    status_word[STATE_LSB + RU_ST_W +: CU_ST_W] = cu_state;
    status_word[STATE_LSB +: RU_ST_W] = ru_state;

    cmd_word = '0;
    cmd_word[CMD_MASK_BIT] = mask_q;
    cmd_word[CMD_CU_LSB +: CU_OP_W] = cu_cmd_op;
    cmd_word[CMD_RU_LSB +: RU_OP_W] = ru_cmd_op;

    host_rdata = '0;
    case (reg_sel_e'(host_addr))
      SEL_STATUS: host_rdata[STAT_W-1:0] = status_word;
      SEL_CMD:    host_rdata[STAT_W-1:0] = cmd_word;
      SEL_PTR:    host_rdata[PTR_W-1:0]  = ptr_q;
      default:    host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/nic_ctl_regs_chk.sv
module nic_ctl_regs_chk
  import nic_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CU_OP_W = 4,
  parameter int RU_OP_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_wr_en,
  input logic [1:0]         host_addr,
  input logic [DATA_W-1:0]  host_wdata,
  input logic [EV_W-1:0]    unit_events,
  input logic [EV_W-1:0]    flags,
  input logic               mask,
  input logic               irq,
  input logic               cu_valid,
  input logic               cu_ready,
  input logic [CU_OP_W-1:0] cu_op,
  input logic               ru_valid,
  input logic               ru_ready,
  input logic [RU_OP_W-1:0] ru_op
);

  logic cmd_wr;
  assign cmd_wr = host_wr_en && (host_addr == 2'd1);

  // R2 / R4: a hardware event always leaves its flag set.
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((unit_events & HW_EVENT_MASK) != '0) |=>
      ((flags & $past(unit_events & HW_EVENT_MASK)) == $past(unit_events & HW_EVENT_MASK)));

  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && host_addr == 2'd0 && (unit_events & HW_EVENT_MASK) == '0) |=>
      ((flags & $past(host_wdata[15:8] & ACK_MASK)) == '0));

  a_r5_swi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && host_wdata[9]) |=> flags[SWI_FLAG_IDX]);

  a_r6_cu_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cu_valid |-> CU_LEGAL[cu_op]);

  a_r7_ru_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ru_valid |-> RU_LEGAL[ru_op]);

  a_r8_cu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_valid && !cu_ready && !cmd_wr) |=> (cu_valid && $stable(cu_op)));

  a_r8_cu_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_valid && cu_ready && !cmd_wr) |=> !cu_valid);

  a_r8_ru_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ru_valid && !ru_ready && !cmd_wr) |=> (ru_valid && $stable(ru_op)));

  a_r8_ru_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ru_valid && ru_ready && !cmd_wr) |=> !ru_valid);

  a_r9_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> !irq);

  a_r9_no_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |=> !irq);

endmodule

bind nic_ctl_regs nic_ctl_regs_chk #(
  .DATA_W(DATA_W), .CU_OP_W(CU_OP_W), .RU_OP_W(RU_OP_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
  .unit_events(unit_events), .flags(flags_q), .mask(mask_q), .irq(irq),
  .cu_valid(cu_cmd_valid), .cu_ready(cu_cmd_ready), .cu_op(cu_cmd_op),
  .ru_valid(ru_cmd_valid), .ru_ready(ru_cmd_ready), .ru_op(ru_cmd_op)
);

// File: tb/nic_ctl_regs_tb.sv
`timescale 1ns/100ps
module nic_ctl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [7:0]  unit_events = '0;
  logic [1:0]  cu_state = '0;
  logic [3:0]  ru_state = '0;
  logic        cu_cmd_valid, ru_cmd_valid;
  logic        cu_cmd_ready = 1'b0;
  logic        ru_cmd_ready = 1'b0;
  logic [3:0]  cu_cmd_op;
  logic [2:0]  ru_cmd_op;
  logic [31:0] cu_cmd_ptr, ru_cmd_ptr;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nic_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .unit_events(unit_events),
    .cu_state(cu_state), .ru_state(ru_state),
    .cu_cmd_valid(cu_cmd_valid), .cu_cmd_ready(cu_cmd_ready),
    .cu_cmd_op(cu_cmd_op), .cu_cmd_ptr(cu_cmd_ptr),
    .ru_cmd_valid(ru_cmd_valid), .ru_cmd_ready(ru_cmd_ready),
    .ru_cmd_op(ru_cmd_op), .ru_cmd_ptr(ru_cmd_ptr),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0; host_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic pulse_ev(input logic [7:0] e);
    @(negedge clk);
    unit_events = e;
    @(negedge clk);
    unit_events = '0;
  endtask

  task automatic accept_cu();
    @(negedge clk); cu_cmd_ready = 1'b1;
    @(negedge clk); cu_cmd_ready = 1'b0;
  endtask

  task automatic accept_ru();
    @(negedge clk); ru_cmd_ready = 1'b1;
    @(negedge clk); ru_cmd_ready = 1'b0;
  endtask

  function automatic bit cu_legal(input int op);
    return (op == 1) || (op == 2) || (op >= 4 && op <= 7);
  endfunction

  function automatic bit ru_legal(input int op);
    return (op == 1) || (op == 2) || (op == 4) || (op == 6) || (op == 7);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 status", d, 32'h0);
    rd(2'd1, d); check("R1 command", d, 32'h0);
    rd(2'd2, d); check("R1 pointer", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 cu_valid", {31'b0, cu_cmd_valid}, 32'h0);

    // R10 state field sweep
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 16; r++) begin
        cu_state = c[1:0]; ru_state = r[3:0];
        rd(2'd0, d);
        check("R10 state fields", d, 32'((c << 6) | (r << 2)));
      end
    end
    cu_state = '0; ru_state = '0;

    // R2 each event input bit alone
    for (int i = 0; i < 8; i++) begin
      pulse_ev(8'(1 << i));
      rd(2'd0, d);
      check("R2 event to flag", d, 32'(((1 << i) & 8'hF9) << 8));
      repeat (3) @(negedge clk);
      rd(2'd0, d);
      check("R2 flag held", d, 32'(((1 << i) & 8'hF9) << 8));
      wr(2'd0, 32'h0000FF00);
      rd(2'd0, d);
      check("R3 full ack", d, 32'h0);
    end

    // R3 / R5 acknowledge byte sweep
    for (int a = 0; a < 256; a++) begin
      wr(2'd1, 32'h00000200);
      pulse_ev(8'hFF);
      wr(2'd0, 32'(a << 8) | 32'hFFFF00FF & 32'hFFFF00FF);
      rd(2'd0, d);
      check("R3 ack sweep", d, 32'((8'hFD & ~(a[7:0] & 8'hFD)) << 8));
      wr(2'd0, 32'h0000FF00);
    end

    // R5 software interrupt
    wr(2'd1, 32'h00000200);
    rd(2'd0, d); check("R5 swi flag", d, 32'h00000400);
    rd(2'd1, d); check("R5 swi reads 0", d, 32'h0);
    wr(2'd0, 32'h0000FF00);

    // R4 event and ack on the same edge
    @(negedge clk);
    unit_events = 8'h80; host_wr_en = 1'b1; host_addr = 2'd0; host_wdata = 32'h0000FF00;
    @(negedge clk);
    unit_events = '0; host_wr_en = 1'b0; host_wdata = '0;
    rd(2'd0, d); check("R4 event beats ack", d, 32'h00008000);
    wr(2'd0, 32'h0000FF00);
    repeat (2) @(negedge clk);

    // R9 interrupt timing
    @(negedge clk); unit_events = 8'h08;
    @(negedge clk); unit_events = '0;
    check("R9 irq low on set edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R9 irq rises next cycle", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h00000800);
    check("R9 irq still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R9 irq falls", {31'b0, irq}, 32'h0);
    pulse_ev(8'h01);
    @(negedge clk);
    check("R9 irq on pause flag", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h00000100);
    rd(2'd1, d); check("R9 mask readback", d, 32'h00000100);
    check("R9 mask lag", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R9 masked", {31'b0, irq}, 32'h0);
    wr(2'd1, 32'h00000000);
    @(negedge clk);
    check("R9 unmasked", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000FF00);
    @(negedge clk);

    // R6 / R11 command-unit opcode sweep
    for (int op = 0; op < 16; op++) begin
      wr(2'd2, 32'hA5000000 | 32'(op));
      wr(2'd1, 32'(op << 4));
      rd(2'd1, d);
      if (cu_legal(op)) begin
        check("R6 cu loaded", {28'b0, cu_cmd_op}, 32'(op));
        check("R6 cu valid", {31'b0, cu_cmd_valid}, 32'h1);
        check("R8 cu readback", d, 32'(op << 4));
        check("R11 cu operand", cu_cmd_ptr, 32'hA5000000 | 32'(op));
        wr(2'd2, 32'h5A5A0000 | 32'(op));
        check("R11 operand kept", cu_cmd_ptr, 32'hA5000000 | 32'(op));
        rd(2'd2, d); check("R11 pointer readback", d, 32'h5A5A0000 | 32'(op));
        accept_cu();
        rd(2'd1, d); check("R8 cu cleared", d, 32'h0);
      end else begin
        check("R6 cu illegal ignored", d, 32'h0);
        check("R6 cu no valid", {31'b0, cu_cmd_valid}, 32'h0);
      end
    end

    // R7 receive-unit opcode sweep
    for (int op = 0; op < 8; op++) begin
      wr(2'd2, 32'h00C00000 | 32'(op));
      wr(2'd1, 32'(op));
      rd(2'd1, d);
      if (ru_legal(op)) begin
        check("R7 ru loaded", {29'b0, ru_cmd_op}, 32'(op));
        check("R7 ru valid", {31'b0, ru_cmd_valid}, 32'h1);
        check("R11 ru operand", ru_cmd_ptr, 32'h00C00000 | 32'(op));
        accept_ru();
        rd(2'd1, d); check("R8 ru cleared", d, 32'h0);
      end else begin
        check("R7 ru illegal ignored", d, 32'h0);
      end
    end

    // R8 independent accepts and holding under back-pressure
    wr(2'd1, 32'h00000061);
    accept_ru();
    rd(2'd1, d); check("R8 ru only cleared", d, 32'h00000060);
    repeat (5) @(negedge clk);
    rd(2'd1, d); check("R8 cu held", d, 32'h00000060);
    accept_cu();
    rd(2'd1, d); check("R8 both clear", d, 32'h0);
    accept_cu();
    check("R8 idle ready no effect", {31'b0, cu_cmd_valid}, 32'h0);

    // R12 replacement cases
    wr(2'd1, 32'h00000010);
    wr(2'd1, 32'h00000030);
    rd(2'd1, d); check("R12 illegal keeps pending", d, 32'h00000010);
    wr(2'd2, 32'h00001234);
    wr(2'd1, 32'h00000020);
    check("R12 replace op", {28'b0, cu_cmd_op}, 32'h2);
    check("R12 replace operand", cu_cmd_ptr, 32'h00001234);
    @(negedge clk);
    cu_cmd_ready = 1'b1; host_wr_en = 1'b1; host_addr = 2'd1; host_wdata = 32'h00000050;
    @(negedge clk);
    cu_cmd_ready = 1'b0; host_wr_en = 1'b0; host_wdata = '0;
    check("R12 write beats accept", {28'b0, cu_cmd_op}, 32'h5);
    accept_cu();
    check("R12 drained", {31'b0, cu_cmd_valid}, 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule